// File: doc/BRIEF.md
# Two-Segment Hybrid Binary Adder

This block adds two N-bit operands and a carry-in, producing an N-bit sum and a carry-out. Internally the operand is cut at a parameter-chosen bit position into a low segment and a high segment. Each segment is built as either a ripple-carry chain or a carry-lookahead tree, chosen by its own parameter. The carry leaving the low segment is the only carry entering the high segment, so the two segments form a strict linear chain. A ripple low part under a lookahead high part suits a critical path where the lower bits settle early.

The lookahead segment works in groups of four bits. A logarithmic prefix network across the groups produces each group's incoming carry, and a short chain inside each group produces the individual bit carries. A segment width of zero removes that segment: the carry then passes straight across the missing segment.

An optional output register stage, selected by a parameter, holds the sum and carry-out. It is cleared by an active-low asynchronous reset. Without the stage the outputs are purely combinational and the clock and reset pins are unused. The block has no flow control: a new operand pair may be presented every cycle.

Top module: `hyb_adder`

## Requirements
- R1: `{carry_out, sum_out}` equals the (WIDTH+1)-bit value `op_a + op_b + carry_in`, with `carry_out` as bit WIDTH.
- R2: The low segment covers bits `[LOW_W-1:0]` and the high segment covers bits `[WIDTH-1:LOW_W]`. The carry out of the low segment is the carry in of the high segment, so a carry raised in the low bits changes the high bits.
- R3: A segment whose architecture parameter is `SEG_RIPPLE` (encoding 0) produces the correct sum and carry for its bits.
- R4: A segment whose architecture parameter is `SEG_LOOKAHEAD` (encoding 1) produces the correct sum and carry, including for segment widths that are not a multiple of four.
- R5: With `LOW_W = 0` the whole operand is one high segment, and `carry_in` feeds it directly.
- R6: With `LOW_W = WIDTH` the high segment is absent, and `carry_out` is the low segment's carry out.
- R7: With `OUT_REG = 1`, the result for inputs sampled at a rising clock edge appears on the outputs after that edge. The outputs hold until the next edge.
- R8: With `OUT_REG = 1`, `sum_out` and `carry_out` are zero while `rst_n` is low, whatever the inputs.
- R9: With `OUT_REG = 0`, the outputs follow the inputs without any clock edge.
- R10: When every bit of `op_a ^ op_b` is one and `carry_in` is one, the carry runs through both segments: `sum_out` is zero and `carry_out` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of bit WIDTH-1 |

## Verification
Two functions can act in the same cycle: carry generation in the low segment and carry propagation through the whole high segment. They overlap when a carry born below the split meets a high segment that propagates in every bit, so a single edge of `carry_in` or of a low bit must ripple into `carry_out`. The bench provokes this with all-ones operands, alternating patterns whose XOR is all ones, and operands that fill exactly the low segment. It judges the full (WIDTH+1)-bit result against a reference sum, and a checker also compares the seam carry with the carry of the low bits alone.

// File: rtl/hyb_add_pkg.sv
package hyb_add_pkg;
  typedef enum logic [0:0] {
    SEG_RIPPLE    = 1'b0,
    SEG_LOOKAHEAD = 1'b1
  } seg_arch_e;

  // bits per lookahead group
  localparam int unsigned GRP_W = 4;
endpackage

// File: rtl/hyb_ripple_seg.sv
module hyb_ripple_seg #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  always_comb begin
    logic c_run;
    c_run = ci;
    for (int i = 0; i < int'(W); i++) begin
      s[i]  = a[i] ^ b[i] ^ c_run;
      c_run = (a[i] & b[i]) | (c_run & (a[i] ^ b[i]));
    end
    co = c_run;
  end
endmodule

// File: rtl/hyb_cla_seg.sv
module hyb_cla_seg
  import hyb_add_pkg::*;
#(
  parameter int unsigned W = 96
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int unsigned NG = (W + GRP_W - 1) / GRP_W;
  localparam int unsigned LV = (NG > 1) ? $clog2(NG) : 0;

  logic [W-1:0]  p_bit, g_bit;
  logic [NG-1:0] grp_g, grp_p;
  logic [LV:0][NG-1:0] pf_g, pf_p;

  assign p_bit = a ^ b;
  assign g_bit = a & b;

  // group generate/propagate over the real bits of each group
  always_comb begin
    for (int j = 0; j < int'(NG); j++) begin
      grp_g[j] = 1'b0;
      grp_p[j] = 1'b1;
      for (int k = 0; k < int'(GRP_W); k++) begin
        if (j * int'(GRP_W) + k < int'(W)) begin
          grp_g[j] = g_bit[j*GRP_W+k] | (p_bit[j*GRP_W+k] & grp_g[j]);
          grp_p[j] = grp_p[j] & p_bit[j*GRP_W+k];
        end
      end
    end
  end

  assign pf_g[0] = grp_g;
  assign pf_p[0] = grp_p;

  // logarithmic prefix across groups
  for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
    for (genvar j = 0; j < NG; j++) begin : g_node
      if (j >= (1 << lv)) begin : g_comb
        assign pf_g[lv+1][j] = pf_g[lv][j] | (pf_p[lv][j] & pf_g[lv][j-(1<<lv)]);
        assign pf_p[lv+1][j] = pf_p[lv][j] & pf_p[lv][j-(1<<lv)];
      end else begin : g_pass
        assign pf_g[lv+1][j] = pf_g[lv][j];
        assign pf_p[lv+1][j] = pf_p[lv][j];
      end
    end
  end

  // bit carries inside each group from the group's incoming carry
  always_comb begin
    logic c_run;
    s = '0;
    for (int j = 0; j < int'(NG); j++) begin
      c_run = (j == 0) ? ci : (pf_g[LV][j-1] | (pf_p[LV][j-1] & ci));
      for (int k = 0; k < int'(GRP_W); k++) begin
        if (j * int'(GRP_W) + k < int'(W)) begin
          s[j*GRP_W+k] = p_bit[j*GRP_W+k] ^ c_run;
          c_run = g_bit[j*GRP_W+k] | (p_bit[j*GRP_W+k] & c_run);
        end
      end
    end
  end

  assign co = pf_g[LV][NG-1] | (pf_p[LV][NG-1] & ci);
endmodule

// File: rtl/hyb_seg.sv
module hyb_seg
  import hyb_add_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter seg_arch_e   ARCH = SEG_RIPPLE
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  if (ARCH == SEG_LOOKAHEAD) begin : g_cla
    hyb_cla_seg #(.W(W)) cla_i (.a(a), .b(b), .ci(ci), .s(s), .co(co));
  end else begin : g_rca
    hyb_ripple_seg #(.W(W)) rca_i (.a(a), .b(b), .ci(ci), .s(s), .co(co));
  end
endmodule

// File: rtl/hyb_adder.sv
module hyb_adder
  import hyb_add_pkg::*;
#(
  parameter int unsigned WIDTH     = 128,
  parameter int unsigned LOW_W     = 32,
  parameter seg_arch_e   LOW_ARCH  = SEG_RIPPLE,
  parameter seg_arch_e   HIGH_ARCH = SEG_LOOKAHEAD,
  parameter bit          OUT_REG   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int unsigned HIGH_W = WIDTH - LOW_W;

  logic [WIDTH-1:0] sum_c;
  logic             seam_c;
  logic             co_c;

  if (LOW_W == 0) begin : g_no_low
    assign seam_c = carry_in;
  end else begin : g_low
    hyb_seg #(.W(LOW_W), .ARCH(LOW_ARCH)) lo_i (
      .a(op_a[LOW_W-1:0]), .b(op_b[LOW_W-1:0]), .ci(carry_in),
      .s(sum_c[LOW_W-1:0]), .co(seam_c)
    );
  end

  if (HIGH_W == 0) begin : g_no_high
    assign co_c = seam_c;
  end else begin : g_high
    hyb_seg #(.W(HIGH_W), .ARCH(HIGH_ARCH)) hi_i (
      .a(op_a[WIDTH-1:LOW_W]), .b(op_b[WIDTH-1:LOW_W]), .ci(seam_c),
      .s(sum_c[WIDTH-1:LOW_W]), .co(co_c)
    );
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_out   <= '0;
        carry_out <= 1'b0;
      end else begin
        sum_out   <= sum_c;
        carry_out <= co_c;
      end
    end
  end else begin : g_comb
    assign sum_out   = sum_c;
    assign carry_out = co_c;
  end
endmodule

// File: rtl/hyb_adder_chk.sv
module hyb_adder_chk #(
  parameter int unsigned WIDTH   = 128,
  parameter int unsigned LOW_W   = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out,
  input logic [WIDTH-1:0] sum_c,
  input logic             co_c,
  input logic             seam_c
);
  logic [WIDTH:0] ref_full;
  logic           armed;

  assign ref_full = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  sum_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {co_c, sum_c} == ref_full);

  // R10
  full_prop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&(op_a ^ op_b)) && carry_in) |-> (co_c && (sum_c == '0)));

  if (LOW_W > 0) begin : g_seam
    logic [LOW_W:0] ref_lo;
    assign ref_lo = {1'b0, op_a[LOW_W-1:0]} + {1'b0, op_b[LOW_W-1:0]}
                  + {{LOW_W{1'b0}}, carry_in};
    // R2
    seam_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seam_c == ref_lo[LOW_W]);
  end

  if (OUT_REG) begin : g_lat
    // R7
    reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ({carry_out, sum_out} == $past(ref_full)));
  end
endmodule

bind hyb_adder hyb_adder_chk #(.WIDTH(WIDTH), .LOW_W(LOW_W), .OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sum_out(sum_out), .carry_out(carry_out), .sum_c(sum_c), .co_c(co_c),
  .seam_c(seam_c)
);

// File: tb/hyb_adder_tb_top.sv
module hyb_adder_tb_top;
  import hyb_add_pkg::*;

  localparam int CLK_P = 10;
  localparam int BW    = 128;
  localparam int SW    = 37;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] a = '0, b = '0;
  logic          cin = 1'b0;

  logic [BW-1:0] big_s;
  logic          big_c;
  logic [SW-1:0] mix_s, nolo_s, nohi_s;
  logic          mix_c, nolo_c, nohi_c;

  int tests = 0;
  int fails = 0;
  logic [BW:0] last_exp = '0;

  always #(CLK_P/2) clk = ~clk;

  hyb_adder dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .carry_in(cin),
    .sum_out(big_s), .carry_out(big_c));

  hyb_adder #(.WIDTH(SW), .LOW_W(13), .LOW_ARCH(SEG_LOOKAHEAD),
              .HIGH_ARCH(SEG_RIPPLE), .OUT_REG(1'b0)) dut_mix_i (
    .clk(clk), .rst_n(rst_n), .op_a(a[SW-1:0]), .op_b(b[SW-1:0]), .carry_in(cin),
    .sum_out(mix_s), .carry_out(mix_c));

  hyb_adder #(.WIDTH(SW), .LOW_W(0), .HIGH_ARCH(SEG_LOOKAHEAD),
              .OUT_REG(1'b0)) dut_nolo_i (
    .clk(clk), .rst_n(rst_n), .op_a(a[SW-1:0]), .op_b(b[SW-1:0]), .carry_in(cin),
    .sum_out(nolo_s), .carry_out(nolo_c));

  hyb_adder #(.WIDTH(SW), .LOW_W(SW), .LOW_ARCH(SEG_RIPPLE),
              .OUT_REG(1'b0)) dut_nohi_i (
    .clk(clk), .rst_n(rst_n), .op_a(a[SW-1:0]), .op_b(b[SW-1:0]), .carry_in(cin),
    .sum_out(nohi_s), .carry_out(nohi_c));

  function automatic logic [BW:0] ref_big(logic [BW-1:0] x, logic [BW-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{BW{1'b0}}, c};
  endfunction

  function automatic logic [SW:0] ref_small(logic [SW-1:0] x, logic [SW-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{SW{1'b0}}, c};
  endfunction

  task automatic check(string req, logic [BW:0] act, logic [BW:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(logic [BW-1:0] xa, logic [BW-1:0] xb, logic xc, string tag);
    logic [BW:0] e;
    logic [SW:0] es;
    @(negedge clk);
    a = xa; b = xb; cin = xc;
    e  = ref_big(xa, xb, xc);
    es = ref_small(xa[SW-1:0], xb[SW-1:0], xc);
    #1;
    check({tag, " R4/R9 mixed comb"}, {{(BW-SW){1'b0}}, mix_c, mix_s}, {{(BW-SW){1'b0}}, es});
    check({tag, " R5 no low seg"}, {{(BW-SW){1'b0}}, nolo_c, nolo_s}, {{(BW-SW){1'b0}}, es});
    check({tag, " R6 no high seg"}, {{(BW-SW){1'b0}}, nohi_c, nohi_s}, {{(BW-SW){1'b0}}, es});
    check({tag, " R7 hold before edge"}, {big_c, big_s}, last_exp);
    @(posedge clk); #1;
    check({tag, " R1/R3 registered"}, {big_c, big_s}, e);
    last_exp = e;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [BW-1:0] alt5, alta, lo_ones;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    alt5    = {(BW/4){4'h5}};
    alta    = {(BW/4){4'hA}};
    lo_ones = {{(BW-32){1'b0}}, 32'hFFFF_FFFF};

    // R8: outputs cleared during reset despite active inputs
    a = '1; b = '1; cin = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset clears", {big_c, big_s}, '0);
    @(negedge clk);
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    run_vec('0, '0, 1'b0, "zero");
    run_vec('1, '1, 1'b1, "R1 all ones");
    run_vec(alt5, alta, 1'b1, "R10 alternating");
    run_vec(alta, alt5, 1'b0, "alt no cin");
    run_vec(lo_ones, '0, 1'b1, "R2 seam carry");
    run_vec(lo_ones, {{(BW-1){1'b0}}, 1'b1}, 1'b0, "R2 seam via b");
    run_vec({{(BW-13){1'b0}}, 13'h1FFF}, {{(BW-1){1'b0}}, 1'b1}, 1'b0, "R2 small seam");
    run_vec('1, '0, 1'b1, "R10 full chain");

    for (int i = 0; i < 200; i++) begin
      run_vec({$urandom, $urandom, $urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom},
              1'($urandom), "random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule